// File: doc/BRIEF.md
# Shared FIFO Load-Lock Arbiter

This block hands out a single load-lock token to one of several DMA channel threads. The threads share one data FIFO. Every cycle each channel reports the class of the instruction it is executing as a 4-bit event code. A channel that reaches a load while the lock is free takes the lock on that load. A channel that meets a load while another channel holds the lock is told to stall. The owner gives the lock back when it reaches a store, a barrier, a wait, its end, or any abort.

The grant and stall outputs are combinational on the event codes of the current cycle. The owner register updates on the next clock edge. When several channels are waiting on a free lock, a round-robin pointer chooses between them. The pointer starts its search at the channel after the most recent owner. When the owner releases in the same cycle that another channel loads, the lock passes to the loader with no idle cycle in between.

Top module: `llk_lock_arbiter`

## Requirements
- R1: After reset `lockValid` is 0, `ownerId` is 0, and no `loadGrant` bit is set.
- R2: Codes 1 (load) and 2 (load-peripheral) are loads. When the lock is free and exactly one channel loads, that channel's `loadGrant` is high in the same cycle. From the next cycle on, `lockValid` is 1 and `ownerId` holds that channel.
- R3: A channel that loads while another channel owns the lock, and the owner is not releasing, gets `loadStall` high and `loadGrant` low. At most one `loadGrant` bit is ever high.
- R4: The owner is granted every load it makes, and it keeps the lock across them.
- R5: An owner event of code 3 (store), 4 (store-peripheral) or 5 (store-zero) frees the lock from the next cycle.
- R6: An owner event of code 6 (read barrier), 7 (write barrier), 8 (wait for peripheral) or 9 (wait for event) frees the lock from the next cycle.
- R7: An owner event of code 10 (end), 11 (abort) or 12 (kill) frees the lock from the next cycle.
- R8: Among channels that load on a free lock in the same cycle, the grant goes to the first one found in the order `ownerId`+1, `ownerId`+2, and so on, modulo the channel count.
- R9: When the owner releases in a cycle where other channels load, one of those loaders is granted in that same cycle. The lock stays valid with the new owner from the next cycle.
- R10: Release codes from channels that do not own the lock have no effect on `lockValid` or `ownerId`.
- R11: Code 0 (idle) and the unused codes 13 to 15 neither claim nor release the lock.
- R12: A channel's `loadStall` is high exactly when it presents a load code and is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evCode | input | 4*NUM_CH | Per-channel event code; channel i uses bits [4i+3:4i] |
| loadGrant | output | NUM_CH | Load may proceed this cycle |
| loadStall | output | NUM_CH | Load must wait this cycle |
| ownerId | output | $clog2(NUM_CH) | Current owner, or the most recent owner while the lock is free |
| lockValid | output | 1 | Lock is held by `ownerId` |

## Verification
The hardest case to reach is a same-cycle handoff that is also contended. The owner must release while two or more other channels load, so that the round-robin order decides who receives the lock with no idle cycle. The directed part builds this case on purpose: one channel holds the lock, two others stall, and then the owner stores. The random part weights load codes heavily so that releases often coincide with several waiting loaders. It compares every cycle against a reference model in the bench.

// File: rtl/llk_pkg.sv
package llk_pkg;
  localparam int EV_W = 4;

  typedef enum logic [EV_W-1:0] {
    EV_IDLE   = 4'd0,
    EV_LOAD   = 4'd1,
    EV_LOADP  = 4'd2,
    EV_STORE  = 4'd3,
    EV_STOREP = 4'd4,
    EV_STOREZ = 4'd5,
    EV_RBAR   = 4'd6,
    EV_WBAR   = 4'd7,
    EV_WAITP  = 4'd8,
    EV_WAITE  = 4'd9,
    EV_END    = 4'd10,
    EV_ABORT  = 4'd11,
    EV_KILL   = 4'd12
  } evCodeE;

  typedef struct packed {
    logic claim;
    logic drop;
  } lockStrobeT;

  function automatic logic isLoadCode(input logic [EV_W-1:0] c);
    return (c == EV_LOAD) || (c == EV_LOADP);
  endfunction

  function automatic logic isReleaseCode(input logic [EV_W-1:0] c);
    return (c >= EV_STORE) && (c <= EV_KILL);
  endfunction
endpackage

// File: rtl/llk_owner_dp.sv
module llk_owner_dp
  import llk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ID_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  lockStrobeT        strobe,
  input  logic [NUM_CH-1:0] reqVec,
  output logic [ID_W-1:0]   ownerId,
  output logic              lockValid,
  output logic [ID_W-1:0]   winnerId,
  output logic              winnerFound
);
  // round-robin search starting after the current/last owner
  always_comb begin
    winnerId    = '0;
    winnerFound = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      int idx;
      idx = (int'(ownerId) + k) % NUM_CH;
      if (!winnerFound && reqVec[idx]) begin
        winnerFound = 1'b1;
        winnerId    = ID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownerId   <= '0;
      lockValid <= 1'b0;
    end else if (strobe.claim) begin
      ownerId   <= winnerId;
      lockValid <= 1'b1;
    end else if (strobe.drop) begin
      lockValid <= 1'b0;
    end
  end
endmodule

// File: rtl/llk_ctrl.sv
module llk_ctrl
  import llk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ID_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH*EV_W-1:0] evCode,
  input  logic [ID_W-1:0]        ownerId,
  input  logic                   lockValid,
  input  logic [ID_W-1:0]        winnerId,
  input  logic                   winnerFound,
  output logic [NUM_CH-1:0]      reqVec,
  output lockStrobeT             strobe,
  output logic [NUM_CH-1:0]      loadGrant,
  output logic [NUM_CH-1:0]      loadStall
);
  logic [NUM_CH-1:0] relVec;
  logic              ownerRel;
  logic              lockFree;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign reqVec[i] = isLoadCode(evCode[i*EV_W +: EV_W]);
    assign relVec[i] = isReleaseCode(evCode[i*EV_W +: EV_W]);
  end

  assign ownerRel     = lockValid & relVec[ownerId];
  assign lockFree     = ~lockValid | ownerRel;
  assign strobe.claim = lockFree & winnerFound;
  assign strobe.drop  = ownerRel & ~strobe.claim;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_grant
    logic isOwner;
    logic isWinner;
    assign isOwner      = lockValid & (ownerId == ID_W'(i));
    assign isWinner     = strobe.claim & (winnerId == ID_W'(i));
    assign loadGrant[i] = reqVec[i] & (isOwner | isWinner);
    assign loadStall[i] = reqVec[i] & ~(isOwner | isWinner);
  end
endmodule

// File: rtl/llk_lock_arbiter.sv
module llk_lock_arbiter
  import llk_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_CH*EV_W-1:0] evCode,
  output logic [NUM_CH-1:0]      loadGrant,
  output logic [NUM_CH-1:0]      loadStall,
  output logic [ID_W-1:0]        ownerId,
  output logic                   lockValid
);
  lockStrobeT        strobe;
  logic [NUM_CH-1:0] reqVec;
  logic [ID_W-1:0]   winnerId;
  logic              winnerFound;

  llk_ctrl #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_ctrl (
    .evCode(evCode), .ownerId(ownerId), .lockValid(lockValid),
    .winnerId(winnerId), .winnerFound(winnerFound), .reqVec(reqVec),
    .strobe(strobe), .loadGrant(loadGrant), .loadStall(loadStall)
  );

  llk_owner_dp #(.NUM_CH(NUM_CH), .ID_W(ID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqVec(reqVec),
    .ownerId(ownerId), .lockValid(lockValid),
    .winnerId(winnerId), .winnerFound(winnerFound)
  );
endmodule

// File: rtl/llk_lock_chk.sv
module llk_lock_chk
  import llk_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ID_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NUM_CH*EV_W-1:0] evCode,
  input logic [NUM_CH-1:0]      loadGrant,
  input logic [NUM_CH-1:0]      loadStall,
  input logic [ID_W-1:0]        ownerId,
  input logic                   lockValid
);
  logic [EV_W-1:0] ownerEv;
  assign ownerEv = evCode[int'(ownerId)*EV_W +: EV_W];

  // R12
  grant_stall_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (loadGrant & loadStall) == '0);

  // R3
  single_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(loadGrant));

  // R2
  claim_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!lockValid && loadGrant != '0) |=> lockValid);

  // R4
  owner_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockValid && !isReleaseCode(ownerEv)) |=> (lockValid && $stable(ownerId)));

  // R5
  release_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockValid && isReleaseCode(ownerEv) && loadGrant == '0) |=> !lockValid);

  // R9
  handoff_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lockValid && isReleaseCode(ownerEv) && loadGrant != '0) |=> lockValid);
endmodule

bind llk_lock_arbiter llk_lock_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .evCode(evCode), .loadGrant(loadGrant),
  .loadStall(loadStall), .ownerId(ownerId), .lockValid(lockValid)
);

// File: tb/llk_lock_arbiter_test.sv
module llk_lock_arbiter_test;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [4*NCH-1:0] evCode = '0;
  logic [NCH-1:0]  loadGrant, loadStall;
  logic [1:0]      ownerId;
  logic            lockValid;

  int nChecks = 0;
  int nFails  = 0;
  bit refValid = 1'b0;
  int refOwner = 0;

  always #4 clk = ~clk;

  llk_lock_arbiter #(.NUM_CH(NCH)) uut (
    .clk(clk), .rstN(rstN), .evCode(evCode), .loadGrant(loadGrant),
    .loadStall(loadStall), .ownerId(ownerId), .lockValid(lockValid)
  );

  function automatic logic [15:0] ev4(int c0, int c1, int c2, int c3);
    return {4'(c3), 4'(c2), 4'(c1), 4'(c0)};
  endfunction

  function automatic bit isLd(int c);
    return c == 1 || c == 2;
  endfunction

  function automatic bit isRel(int c);
    return c >= 3 && c <= 12;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle, compare against model, advance model
  task automatic step(logic [15:0] ev, string tag);
    logic [NCH-1:0] ld, expG;
    bit ownerRel, free;
    int win;
    @(negedge clk);
    evCode = ev;
    #1;
    ld = '0;
    for (int i = 0; i < NCH; i++) ld[i] = isLd(int'(ev[i*4 +: 4]));
    ownerRel = refValid && isRel(int'(ev[refOwner*4 +: 4]));
    free = !refValid || ownerRel;
    win = -1;
    for (int k = 1; k <= NCH; k++) begin
      int c;
      c = (refOwner + k) % NCH;
      if (win < 0 && ld[c]) win = c;
    end
    expG = '0;
    if (refValid && ld[refOwner]) expG[refOwner] = 1'b1;
    if (free && win >= 0) expG[win] = 1'b1;
    check(lockValid == refValid, {tag, " lockValid"}, int'(lockValid), int'(refValid));
    check(int'(ownerId) == refOwner, {tag, " ownerId"}, int'(ownerId), refOwner);
    check(loadGrant == expG, {tag, " loadGrant"}, int'(loadGrant), int'(expG));
    check(loadStall == (ld & ~expG), {tag, " loadStall R12"}, int'(loadStall),
          int'(ld & ~expG));
    if (free && win >= 0) begin
      refValid = 1'b1;
      refOwner = win;
    end else if (ownerRel) begin
      refValid = 1'b0;
    end
  endtask

  initial begin
    #1_000_000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    // R1
    check(lockValid == 1'b0, "R1 lockValid", int'(lockValid), 0);
    check(ownerId == 2'd0, "R1 ownerId", int'(ownerId), 0);
    check(loadGrant == '0, "R1 loadGrant", int'(loadGrant), 0);
    @(negedge clk);
    rstN = 1'b1;
    step(ev4(0, 0, 0, 0), "R1 idle");
    step(ev4(0, 0, 2, 0), "R2 claim ch2");
    step(ev4(0, 1, 1, 0), "R3 R4 owner load, ch1 stalls");
    step(ev4(3, 2, 0, 12), "R10 non-owner release ignored");
    step(ev4(0, 1, 15, 0), "R11 unused code from owner");
    step(ev4(0, 1, 13, 1), "R3 two stalled");
    step(ev4(0, 1, 3, 1), "R8 R9 handoff to ch3");
    for (int code = 3; code <= 12; code++) begin
      step(ev4(0, 0, 0, code), code <= 5 ? "R5 release" :
                                code <= 9 ? "R6 release" : "R7 release");
      step(ev4(0, 0, 0, 0), "R11 idle after release");
      step(ev4(0, 0, 0, 1), "R2 reclaim ch3");
    end
    step(ev4(1, 1, 1, 10), "R8 R9 wrap order");
    step(ev4(1, 1, 1, 1), "R8 R3 contention");
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] ev;
      for (int i = 0; i < NCH; i++) begin
        int r;
        r = int'($urandom_range(0, 9));
        ev[i*4 +: 4] = (r < 4) ? 4'(1 + (r & 1)) : 4'($urandom_range(0, 15));
      end
      step(ev, "R2/R3/R4/R5/R6/R7/R8/R9/R10/R11 random");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule